// File: doc/BRIEF.md
# Multi-Speed Expansion Bus Cycle Generator

This block is the host-side engine for an expansion I/O bus. Each request from the host starts one bus cycle, a read or a write of 8 or 16 bits. Two address bits pick the access speed for that cycle. The speed can be slow, medium, fast, or synchronous to a 2 MHz bus clock. The block drives an active-low peripheral strobe and holds the address, direction, width and write data stable while the strobe is low. On a read it captures the bus data at the moment the strobe is released.

In the three timed speeds, the strobe width is a fixed number of system clocks. With the intended 16 MHz system clock these widths are 625, 500 and 375 ns. A synchronous cycle first waits for a rising edge of the 2 MHz bus clock. It then ends on that clock's next falling edge. Any cycle can be lengthened by an external stretch input, because the memory controller may hold the bus for refresh or video transfers.

The host keeps `req` high until it sees `ready`. `ready` is a single-clock pulse, and read data is valid in the same clock.

Top module: `iob_cycle_gen`

## Requirements
- R1: While reset is high and in the first clock after reset, `io_strobe_n` is 1 and `ready` and `io_oe` are 0.
- R2: The speed is taken from `req_addr[20:19]` as each request is accepted: 00 slow, 01 medium, 10 fast, 11 synchronous.
- R3: With `stretch` low, the strobe stays low for exactly 10 clocks in slow mode, 8 in medium mode and 6 in fast mode.
- R4: `ready` is high for exactly one clock. That clock is the first one in which `io_strobe_n` is high again, and `ready` is never high at any other time.
- R5: A read captures `io_din` when the strobe ends. A 16-bit read returns it whole on `rdata`. An 8-bit read returns `io_din[7:0]` in `rdata[7:0]` with `rdata[15:8]` = 0.
- R6: During a write, `io_oe` is 1 for every clock of the strobe and `io_dout` equals `req_wdata`. For an 8-bit write, `io_dout[15:8]` is 0. `io_oe` is 0 throughout a read.
- R7: Each clock edge at which `stretch` is high while the strobe is low keeps the strobe low for one more clock, in every mode.
- R8: A synchronous cycle drives the strobe low two clocks after a rising edge of `bclk`. It releases the strobe two clocks after the next falling edge of `bclk`, so the strobe is low for half a `bclk` period (4 clocks at an 8-clock period).
- R9: In synchronous mode, a falling edge of `bclk` that is detected while `stretch` is high does not end the cycle. The cycle ends at the next detected falling edge.
- R10: A request is accepted only when the engine is idle and `ready` is low. If `req` is still high in the `ready` clock, no second cycle starts.
- R11: `io_addr`, `io_we` and `io_wide` stay constant while the strobe is low, even if the host inputs change during the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, held until `ready` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit, 0 = 8-bit |
| req_addr | input | ADDR_W | Bus address; bits [20:19] select the speed |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Read data, valid with `ready` |
| bclk | input | 1 | 2 MHz bus clock |
| stretch | input | 1 | Cycle stretch request |
| io_strobe_n | output | 1 | Active-low peripheral strobe |
| io_addr | output | ADDR_W | Latched bus address |
| io_we | output | 1 | Latched direction |
| io_wide | output | 1 | Latched transfer width |
| io_dout | output | DATA_W | Write data to bus |
| io_oe | output | 1 | Write data drive enable |
| io_din | input | DATA_W | Read data from bus |

## Verification
The bound checker watches several properties on every clock. It checks that the timed-mode strobe width equals the nominal count plus the number of stretched clocks, and that `ready` pulses exactly once as the strobe rises. It also checks that a high stretch always extends a low strobe, that the output enable never appears outside a strobe, and that the address and control stay stable while the strobe is low. Some behaviour is visible only through the bench's scenarios, because it depends on the bus-clock phase and on data values. These scenarios show the alignment of synchronous cycles to `bclk` edges and a skipped falling edge under stretch. They also show byte masking on narrow reads and writes, and that a request held over the `ready` clock is ignored.

// File: rtl/iob_pkg.sv
package iob_pkg;

    typedef enum logic [1:0] {
        SPD_SLOW = 2'b00,
        SPD_MED  = 2'b01,
        SPD_FAST = 2'b10,
        SPD_SYNC = 2'b11
    } speed_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SYNC_WAIT = 2'd1,
        ST_STROBE    = 2'd2
    } state_e;

    typedef struct packed {
        logic   we;
        logic   wide;
        speed_e speed;
    } xfer_attr_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Nominal strobe width in system clocks; synchronous mode is edge-timed (0).
    function automatic int unsigned nominal_clks(input speed_e s, input int unsigned slow_c,
                                                 input int unsigned med_c,
                                                 input int unsigned fast_c);
        case (s)
            SPD_SLOW: return slow_c;
            SPD_MED:  return med_c;
            SPD_FAST: return fast_c;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/iob_speed_decode.sv
module iob_speed_decode
    import iob_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int SPEED_LSB = 19,
    parameter int SLOW_CLKS = 10,
    parameter int MED_CLKS  = 8,
    parameter int FAST_CLKS = 6,
    parameter int CNT_W     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output speed_e            speed,
    output logic [CNT_W-1:0]  width
);

    assign speed = speed_e'(addr[SPEED_LSB +: 2]);

    always_comb begin
        width = CNT_W'(nominal_clks(speed, SLOW_CLKS, MED_CLKS, FAST_CLKS));
    end

endmodule

// File: rtl/iob_edge_detect.sv
module iob_edge_detect #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] samp_q;
    logic              hist_q;
    logic              level;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) samp_q <= '0;
                else     samp_q <= sig_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) samp_q <= '0;
                else     samp_q <= {samp_q[STAGES-2:0], sig_in};
            end
        end
    endgenerate

    assign level = samp_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) hist_q <= 1'b0;
        else     hist_q <= level;
    end

    assign rise = level & ~hist_q;
    assign fall = ~level & hist_q;

endmodule

// File: rtl/iob_strobe_timer.sv
module iob_strobe_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             hold,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && !hold && cnt_q > CNT_W'(1)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last = run && !hold && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/iob_cycle_fsm.sv
module iob_cycle_fsm
    import iob_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  speed_e            req_speed,
    input  logic              bclk_rise,
    input  logic              bclk_fall,
    input  logic              stretch,
    input  logic              timer_last,
    input  logic [DATA_W-1:0] io_din,
    output logic              accept,
    output logic              strobe_run,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              io_strobe_n,
    output logic [ADDR_W-1:0] io_addr,
    output logic              io_we,
    output logic              io_wide,
    output logic [DATA_W-1:0] io_dout,
    output logic              io_oe
);

    localparam int NARROW_W = DATA_W / 2;

    state_e     state_q;
    xfer_attr_t attr_q;
    logic       strobe_end;

    function automatic logic [DATA_W-1:0] size_mask(input logic [DATA_W-1:0] v,
                                                    input logic wide);
        return wide ? v : {{(DATA_W-NARROW_W){1'b0}}, v[NARROW_W-1:0]};
    endfunction

    assign accept     = (state_q == ST_IDLE) && req && !ready;
    assign strobe_run = (state_q == ST_STROBE);
    assign strobe_end = strobe_run &&
                        ((attr_q.speed == SPD_SYNC) ? (bclk_fall && !stretch) : timer_last);

    assign io_we   = attr_q.we;
    assign io_wide = attr_q.wide;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            attr_q      <= '{we: 1'b0, wide: 1'b0, speed: SPD_SLOW};
            ready       <= 1'b0;
            rdata       <= '0;
            io_strobe_n <= 1'b1;
            io_addr     <= '0;
            io_dout     <= '0;
            io_oe       <= 1'b0;
        end else begin
            ready <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        attr_q  <= '{we: req_we, wide: req_wide, speed: req_speed};
                        io_addr <= req_addr;
                        io_dout <= size_mask(req_wdata, req_wide);
                        if (req_speed == SPD_SYNC) begin
                            state_q <= ST_SYNC_WAIT;
                        end else begin
                            state_q     <= ST_STROBE;
                            io_strobe_n <= 1'b0;
                            io_oe       <= req_we;
                        end
                    end
                end
                ST_SYNC_WAIT: begin
                    if (bclk_rise) begin
                        state_q     <= ST_STROBE;
                        io_strobe_n <= 1'b0;
                        io_oe       <= attr_q.we;
                    end
                end
                ST_STROBE: begin
                    if (strobe_end) begin
                        state_q     <= ST_IDLE;
                        io_strobe_n <= 1'b1;
                        io_oe       <= 1'b0;
                        ready       <= 1'b1;
                        if (!attr_q.we) rdata <= size_mask(io_din, attr_q.wide);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/iob_cycle_gen.sv
module iob_cycle_gen
    import iob_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 16,
    parameter int SPEED_LSB   = 19,
    parameter int SLOW_CLKS   = 10,
    parameter int MED_CLKS    = 8,
    parameter int FAST_CLKS   = 6,
    parameter int BCLK_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    input  logic              bclk,
    input  logic              stretch,
    output logic              io_strobe_n,
    output logic [ADDR_W-1:0] io_addr,
    output logic              io_we,
    output logic              io_wide,
    output logic [DATA_W-1:0] io_dout,
    output logic              io_oe,
    input  logic [DATA_W-1:0] io_din
);

    localparam int MAX_CLKS = int'(max3(SLOW_CLKS, MED_CLKS, FAST_CLKS));
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);

    speed_e           dec_speed;
    logic [CNT_W-1:0] dec_width;
    logic             bclk_rise;
    logic             bclk_fall;
    logic             accept;
    logic             strobe_run;
    logic             timer_last;

    iob_speed_decode #(
        .ADDR_W   (ADDR_W),
        .SPEED_LSB(SPEED_LSB),
        .SLOW_CLKS(SLOW_CLKS),
        .MED_CLKS (MED_CLKS),
        .FAST_CLKS(FAST_CLKS),
        .CNT_W    (CNT_W)
    ) u_decode (
        .addr (req_addr),
        .speed(dec_speed),
        .width(dec_width)
    );

    iob_edge_detect #(
        .STAGES(BCLK_STAGES)
    ) u_bclk_edge (
        .clk   (clk),
        .rst   (rst),
        .sig_in(bclk),
        .rise  (bclk_rise),
        .fall  (bclk_fall)
    );

    iob_strobe_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .load_val(dec_width),
        .run     (strobe_run),
        .hold    (stretch),
        .last    (timer_last)
    );

    iob_cycle_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .req_we     (req_we),
        .req_wide   (req_wide),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_speed  (dec_speed),
        .bclk_rise  (bclk_rise),
        .bclk_fall  (bclk_fall),
        .stretch    (stretch),
        .timer_last (timer_last),
        .io_din     (io_din),
        .accept     (accept),
        .strobe_run (strobe_run),
        .ready      (ready),
        .rdata      (rdata),
        .io_strobe_n(io_strobe_n),
        .io_addr    (io_addr),
        .io_we      (io_we),
        .io_wide    (io_wide),
        .io_dout    (io_dout),
        .io_oe      (io_oe)
    );

endmodule

// File: rtl/iob_cycle_gen_chk.sv
module iob_cycle_gen_chk
    import iob_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int SPEED_LSB = 19,
    parameter int SLOW_CLKS = 10,
    parameter int MED_CLKS  = 8,
    parameter int FAST_CLKS = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              io_strobe_n,
    input logic              ready,
    input logic              stretch,
    input logic              io_oe,
    input logic              io_we,
    input logic              io_wide,
    input logic [ADDR_W-1:0] io_addr
);

    logic [15:0] low_cnt;
    logic [15:0] str_cnt;
    speed_e      cur_speed;
    logic [15:0] expect_w;

    assign cur_speed = speed_e'(io_addr[SPEED_LSB +: 2]);
    assign expect_w  = 16'(nominal_clks(cur_speed, SLOW_CLKS, MED_CLKS, FAST_CLKS)) + str_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            str_cnt <= '0;
        end else if (!io_strobe_n) begin
            low_cnt <= low_cnt + 16'd1;
            str_cnt <= str_cnt + {15'd0, stretch};
        end else begin
            low_cnt <= '0;
            str_cnt <= '0;
        end
    end

    // R1: reset leaves the bus idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (io_strobe_n && !ready && !io_oe));

    // R3 and R7: timed-mode width equals nominal plus stretched clocks
    a_r3_timed_width: assert property (@(posedge clk) disable iff (rst)
        ($rose(io_strobe_n) && cur_speed != SPD_SYNC) |-> (low_cnt == expect_w));

    // R4: ready coincides with the strobe returning high
    a_r4_ready_on_rise: assert property (@(posedge clk) disable iff (rst)
        ready |-> $rose(io_strobe_n));

    a_r4_rise_gives_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(io_strobe_n) |-> ready);

    a_r4_ready_single: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    // R6: write drive only inside a strobe of a write
    a_r6_oe_in_write_strobe: assert property (@(posedge clk) disable iff (rst)
        io_oe |-> (!io_strobe_n && io_we));

    // R7: a stretch seen during the strobe keeps it low
    a_r7_stretch_holds: assert property (@(posedge clk) disable iff (rst)
        (stretch && !io_strobe_n) |=> !io_strobe_n);

    // R11: bus address and controls frozen while the strobe is low
    a_r11_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!io_strobe_n && $past(!io_strobe_n)) |->
            ($stable(io_addr) && $stable(io_we) && $stable(io_wide)));

endmodule

bind iob_cycle_gen iob_cycle_gen_chk #(
    .ADDR_W   (ADDR_W),
    .SPEED_LSB(SPEED_LSB),
    .SLOW_CLKS(SLOW_CLKS),
    .MED_CLKS (MED_CLKS),
    .FAST_CLKS(FAST_CLKS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .io_strobe_n(io_strobe_n),
    .ready      (ready),
    .stretch    (stretch),
    .io_oe      (io_oe),
    .io_we      (io_we),
    .io_wide    (io_wide),
    .io_addr    (io_addr)
);

// File: tb/tb_iob_cycle_gen.sv
module tb_iob_cycle_gen;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;

    typedef struct packed {
        logic [1:0]  spd;
        logic        we;
        logic        wide;
        logic [15:0] wd;
        logic [15:0] din;
        logic [7:0]  k;
        logic [7:0]  w;
    } vec_t;

    // speed, write, wide, wdata, bus data, stretch clocks, expected width
    localparam vec_t VECS [11] = '{
        '{2'd0, 1'b0, 1'b1, 16'h0000, 16'hA55A, 8'd0, 8'd10},
        '{2'd1, 1'b0, 1'b0, 16'h0000, 16'h12C3, 8'd0, 8'd8},
        '{2'd2, 1'b0, 1'b1, 16'h0000, 16'hBEEF, 8'd0, 8'd6},
        '{2'd3, 1'b0, 1'b1, 16'h0000, 16'h0F0F, 8'd0, 8'd4},
        '{2'd0, 1'b1, 1'b1, 16'h1234, 16'h0000, 8'd0, 8'd10},
        '{2'd2, 1'b1, 1'b0, 16'hABCD, 16'h0000, 8'd0, 8'd6},
        '{2'd1, 1'b0, 1'b1, 16'h0000, 16'h6E71, 8'd3, 8'd11},
        '{2'd2, 1'b1, 1'b1, 16'hC0DE, 16'h0000, 8'd2, 8'd8},
        '{2'd3, 1'b1, 1'b0, 16'h7788, 16'h0000, 8'd0, 8'd4},
        '{2'd3, 1'b0, 1'b0, 16'h0000, 16'h5A3C, 8'd5, 8'd12},
        '{2'd0, 1'b0, 1'b0, 16'h0000, 16'h9966, 8'd1, 8'd11}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic              req_we = 1'b0;
    logic              req_wide = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              ready;
    logic [DATA_W-1:0] rdata;
    logic              bclk = 1'b0;
    logic              stretch = 1'b0;
    logic              io_strobe_n;
    logic [ADDR_W-1:0] io_addr;
    logic              io_we;
    logic              io_wide;
    logic [DATA_W-1:0] io_dout;
    logic              io_oe;
    logic [DATA_W-1:0] io_din = '0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // monitor state
    int          low_cnt = 0;
    int          last_width = 0;
    int          falls = 0;
    int          stretch_left = 0;
    int          ph = 0;
    bit          prev_low = 0;
    bit          prev_ready = 0;
    bit          ready_long = 0;
    bit          ready_at_rise = 0;
    bit          bclk_at_fall = 0;
    bit          bclk_at_rise = 0;
    bit          oe_all = 0;
    bit          oe_any = 0;
    logic [15:0] dout_obs = '0;

    iob_cycle_gen dut (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .rdata(rdata),
        .bclk(bclk), .stretch(stretch), .io_strobe_n(io_strobe_n), .io_addr(io_addr),
        .io_we(io_we), .io_wide(io_wide), .io_dout(io_dout), .io_oe(io_oe), .io_din(io_din)
    );

    always #5 clk = ~clk;

    // Sample outputs, then drive stretch and bclk (8-clock period), all at negedge.
    always @(negedge clk) begin
        if (!io_strobe_n) begin
            if (!prev_low) begin
                low_cnt      = 1;
                falls        = falls + 1;
                bclk_at_fall = bclk;
                oe_all       = io_oe;
                oe_any       = io_oe;
                dout_obs     = io_dout;
            end else begin
                low_cnt = low_cnt + 1;
                oe_all  = oe_all & io_oe;
                oe_any  = oe_any | io_oe;
                if (io_dout != dout_obs) oe_all = 0;
            end
        end else if (prev_low) begin
            last_width    = low_cnt;
            bclk_at_rise  = bclk;
            ready_at_rise = ready;
        end
        if (ready && prev_ready) ready_long = 1;
        prev_ready = ready;
        prev_low   = !io_strobe_n;
        if (!io_strobe_n && stretch_left > 0) begin
            stretch      = 1'b1;
            stretch_left = stretch_left - 1;
        end else begin
            stretch = 1'b0;
        end
        ph   = (ph + 1) % 8;
        bclk = (ph < 4);
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic start_req(input logic [1:0] spd, input logic we, input logic wide,
                             input logic [15:0] wd, input logic [15:0] din, input int k);
        @(negedge clk);
        io_din       = din;
        stretch_left = k;
        req          = 1'b1;
        req_we       = we;
        req_wide     = wide;
        req_addr     = {3'b000, spd, 19'h2A5C5};
        req_wdata    = wd;
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!ready);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check(io_strobe_n && !ready && !io_oe, "R1", "idle during reset",
              {io_strobe_n, ready, io_oe}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        check(io_strobe_n && !ready && !io_oe, "R1", "idle after reset",
              {io_strobe_n, ready, io_oe}, 3'b100);

        // Vector table: R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < 11; i++) begin
            vec_t v;
            v = VECS[i];
            start_req(v.spd, v.we, v.wide, v.wd, v.din, int'(v.k));
            wait_ready();
            req = 1'b0;
            #1;
            check(last_width == int'(v.w), (v.spd == 2'd3) ? "R8/R9" : "R2/R3/R7",
                  $sformatf("strobe width vec %0d", i), last_width, v.w);
            check(ready_at_rise, "R4", $sformatf("ready at strobe rise vec %0d", i),
                  ready_at_rise, 1);
            if (v.we) begin
                check(oe_all && dout_obs == (v.wide ? v.wd : {8'h00, v.wd[7:0]}), "R6",
                      $sformatf("write drive vec %0d", i), dout_obs,
                      v.wide ? v.wd : {8'h00, v.wd[7:0]});
            end else begin
                check(!oe_any, "R6", $sformatf("no drive on read vec %0d", i), oe_any, 0);
                check(rdata == (v.wide ? v.din : {8'h00, v.din[7:0]}), "R5",
                      $sformatf("read data vec %0d", i), rdata,
                      v.wide ? v.din : {8'h00, v.din[7:0]});
            end
            if (v.spd == 2'd3) begin
                check(bclk_at_fall && !bclk_at_rise, "R8",
                      $sformatf("bclk phase at strobe edges vec %0d", i),
                      {bclk_at_fall, bclk_at_rise}, 2'b10);
            end
        end
        check(!ready_long, "R4", "ready never longer than one clock", ready_long, 0);

        // R10: req still high in the ready clock starts nothing
        begin
            int f0;
            start_req(2'd2, 1'b0, 1'b1, 16'h0, 16'h4444, 0);
            wait_ready();
            f0 = falls;
            @(posedge clk);
            #1 req = 1'b0;
            repeat (12) @(negedge clk);
            #1;
            check(falls == f0 && io_strobe_n, "R10", "no second cycle", falls - f0, 0);
        end

        // R11: host inputs change during a slow cycle
        begin
            logic [ADDR_W-1:0] a0;
            start_req(2'd0, 1'b1, 1'b1, 16'h3C3C, 16'h0, 0);
            a0 = req_addr;
            repeat (3) @(negedge clk);
            req_addr  = {3'b000, 2'd2, 19'h00011};
            req_wdata = 16'hFFFF;
            req_we    = 1'b0;
            wait_ready();
            req = 1'b0;
            #1;
            check(io_addr == a0 && io_we, "R11", "address and direction held",
                  io_addr, a0);
            check(last_width == 10 && oe_all && dout_obs == 16'h3C3C, "R11",
                  "width and data from accepted request", last_width, 10);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule